// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer with a small register port. A slow-clock enable is divided by a parameterised ratio, 128 by default. Each divided tick counts a 12-bit down-counter towards zero. Software keeps the system alive by writing a keyed restart command, which reloads the counter from a programmed value. If the counter underflows, the block issues a reset request of fixed length. Depending on configuration, the request goes either to the whole system or only to the processor.

Configuration lives in one mode register that accepts only the first write after reset. The mode register holds:
- the reload value;
- a window value that can forbid early restarts;
- a reset enable;
- a processor-only selector;
- a debug-halt enable;
- a disable bit.

A status register reports underflow and window-violation events, together with the live counter value. Reading the status register clears the event flags.

Top module: `guard_timer`

## Requirements
- R1: After reset both request outputs are low. The status register (address 2) reads 0x0FFF0000, meaning the counter is 0xFFF and both flags are clear. The mode register (address 1) reads 0x5FFFFFF, meaning reload 0xFFF, window 0xFFF, reset enable 1 and debug-halt enable 1.
- R2: A write to address 0 with 0xA5 in bits 31:24 and bit 0 set is a keyed restart. It loads the counter with the reload value in mode bits 11:0 and clears the prescaler. With `slow_tick` high every cycle and reload N, the underflow request starts (N+1)*128 clocks after the restart edge. The counter then reloads and counts again.
- R3: Every reset request is a pulse of exactly 4 clocks. It appears on `cpu_rst_req` when mode bit 25 is 1, and on `sys_rst_req` otherwise. The two outputs are never high together.
- R4: The mode register takes only the first write after reset. Its layout is stop bit 27, debug-halt enable bit 26, processor-only bit 25, reset enable bit 24, window 23:12 and reload 11:0. Later writes leave it unchanged.
- R5: A write to address 0 without key 0xA5 in bits 31:24, or without bit 0 set, changes no state.
- R6: When mode bit 27 is set, the counter and prescaler stop. Keyed restarts are ignored and no request is raised. The bit reads back as 1.
- R7: When mode bit 26 is set and `dbg_halt` is high, counting is frozen. The timeout is lengthened by the number of halted clocks.
- R8: When the window field is below 0xFFF and a keyed restart arrives while the counter is above the window, three things happen: status bit 1 is set, a request pulse is raised if reset enable is set, and the counter is reloaded. A restart with the counter at or below the window is accepted normally.
- R9: With mode bit 24 clear, an underflow raises no request but still sets status bit 0.
- R10: Status bit 0 (underflow) and bit 1 (window error) hold until a read of address 2. That read returns them and then clears them. Status bits 27:16 show the counter.
- R11: With the window field at 0xFFF, a keyed restart is accepted at any counter value and sets no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Slow-clock enable, one pulse per slow period |
| dbg_halt | input | 1 | Debugger halt indication |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on address 2) |
| reg_addr | input | 2 | Register select: 0 control, 1 mode, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the selected register |
| sys_rst_req | output | 1 | System-wide reset request pulse |
| cpu_rst_req | output | 1 | Processor-only reset request pulse |

## Verification
Random reload values and target selections measure the restart-to-request distance. This separates a correct N+1 tick period from off-by-one reload or prescaler faults, and also shows whether the pulse lands on the right output.

Several directed patterns each change one thing against a known timeout:
- an unkeyed or bit-0-less control write in mid-period;
- a held debug halt;
- a disabled timer;
- a second mode write.

Each case distinguishes "ignored" from "acted on" through the measured delay or read-back.

A restart above and then inside a narrow window tells rejection from acceptance. Two successive status reads with resets disabled tell sticky flags from clear-on-read.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

    localparam int CNT_W  = 12;
    localparam int KEY_W  = 8;
    localparam int DATA_W = 32;
    localparam int STAT_CNT_LSB = 16;
    localparam logic [KEY_W-1:0] RESTART_KEY = 8'hA5;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MODE = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             stop;
        logic             halt_en;
        logic             cpu_only;
        logic             rst_en;
        logic [CNT_W-1:0] window;
        logic [CNT_W-1:0] reload;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic mode_t mode_reset();
        mode_t m;
        m.stop     = 1'b0;
        m.halt_en  = 1'b1;
        m.cpu_only = 1'b0;
        m.rst_en   = 1'b1;
        m.window   = '1;
        m.reload   = '1;
        return m;
    endfunction

    function automatic logic is_keyed_restart(input logic [DATA_W-1:0] d);
        return (d[DATA_W-1 -: KEY_W] == RESTART_KEY) && d[0];
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(
        input logic [CNT_W-1:0] count,
        input logic             win_err,
        input logic             underflow);
        logic [DATA_W-1:0] r;
        r = '0;
        r[STAT_CNT_LSB +: CNT_W] = count;
        r[1] = win_err;
        r[0] = underflow;
        return r;
    endfunction

endpackage

// File: rtl/guard_prescaler.sv
module guard_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic step,
    input  logic clear,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_q;
    logic          at_end;

    assign at_end = (pre_q == PW'(DIV - 1));
    assign tick   = run && step && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_q <= '0;
        end else if (run && step) begin
            pre_q <= at_end ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/guard_countdown.sv
module guard_countdown #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         wrap
);
    assign wrap = tick && (count == '0) && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '1;
        end else if (load) begin
            count <= reload;
        end else if (tick) begin
            count <= (count == '0) ? reload : count - 1'b1;
        end
    end
endmodule

// File: rtl/guard_pulse.sv
module guard_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic to_cpu,
    output logic sys_req,
    output logic cpu_req
);
    localparam int LW = $clog2(LEN + 1);

    logic [LW-1:0] left_q;
    logic          cpu_q;
    logic          active;

    assign active  = (left_q != '0);
    assign sys_req = active && !cpu_q;
    assign cpu_req = active && cpu_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            cpu_q  <= 1'b0;
        end else if (fire) begin
            left_q <= LW'(LEN);
            cpu_q  <= to_cpu;
        end else if (active) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_timer_pkg::*;
#(
    parameter int DIV       = 128,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic              dbg_halt,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sys_rst_req,
    output logic              cpu_rst_req
);
    reg_sel_e         sel;
    mode_t            mode_q;
    logic             locked_q;
    logic             unf_q, err_q;
    logic [CNT_W-1:0] cnt;
    logic             run, tick, wrap;
    logic             keyed, win_open, win_err, underflow, fire, stat_rd;

    assign sel = reg_sel_e'(reg_addr);

    // mode register, locked after its first write
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= mode_reset();
            locked_q <= 1'b0;
        end else if (reg_wr && sel == SEL_MODE && !locked_q) begin
            mode_q   <= mode_t'(reg_wdata[MODE_W-1:0]);
            locked_q <= 1'b1;
        end
    end

    // restart decode and window rule
    assign keyed    = reg_wr && sel == SEL_CTRL && is_keyed_restart(reg_wdata) && !mode_q.stop;
    assign win_open = (mode_q.window == '1) || (cnt <= mode_q.window);
    assign win_err  = keyed && !win_open;
    assign run      = !mode_q.stop && !(mode_q.halt_en && dbg_halt);

    guard_prescaler #(.DIV(DIV)) i_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .step  (slow_tick),
        .clear (keyed),
        .tick  (tick)
    );

    guard_countdown #(.W(CNT_W)) i_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .load   (keyed),
        .reload (mode_q.reload),
        .count  (cnt),
        .wrap   (wrap)
    );

    assign underflow = wrap;
    assign fire      = (underflow || win_err) && mode_q.rst_en;

    guard_pulse #(.LEN(PULSE_LEN)) i_pulse (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .to_cpu  (mode_q.cpu_only),
        .sys_req (sys_rst_req),
        .cpu_req (cpu_rst_req)
    );

    // sticky status flags, cleared by a status read
    assign stat_rd = reg_rd && sel == SEL_STAT;

    always_ff @(posedge clk) begin
        if (rst) begin
            unf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (underflow)    unf_q <= 1'b1;
            else if (stat_rd) unf_q <= 1'b0;
            if (win_err)      err_q <= 1'b1;
            else if (stat_rd) err_q <= 1'b0;
        end
    end

    always_comb begin
        case (sel)
            SEL_MODE: reg_rdata = DATA_W'(mode_q);
            SEL_STAT: reg_rdata = pack_status(cnt, err_q, unf_q);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
    import guard_timer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             dbg_halt,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [KEY_W-1:0] ctl_key,
    input mode_t            mode_q,
    input logic             locked_q,
    input logic [CNT_W-1:0] cnt,
    input logic             sys_rst_req,
    input logic             cpu_rst_req
);
    assert_one_target_R3: assert property (@(posedge clk) disable iff (rst)
        !(sys_rst_req && cpu_rst_req));

    assert_sys_pulse_min_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_req) |=> sys_rst_req);

    assert_cpu_pulse_min_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_rst_req) |=> cpu_rst_req);

    assert_mode_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> $stable(mode_q));

    assert_unkeyed_no_load_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && ctl_key != RESTART_KEY && cnt != '0)
        |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

    assert_stop_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        mode_q.stop |=> $stable(cnt));

    assert_halt_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q.halt_en && dbg_halt && !(reg_wr && reg_addr == 2'd0)) |=> $stable(cnt));
endmodule

bind guard_timer guard_timer_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .dbg_halt    (dbg_halt),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .ctl_key     (reg_wdata[31:24]),
    .mode_q      (mode_q),
    .locked_q    (locked_q),
    .cnt         (cnt),
    .sys_rst_req (sys_rst_req),
    .cpu_rst_req (cpu_rst_req)
);

// File: tb/test_guard_timer.sv
`timescale 1ns/1ps
module test_guard_timer;
    localparam int DIV = 128;
    localparam logic [31:0] KEYED   = 32'hA500_0001;
    localparam logic [31:0] BADKEY  = 32'h5A00_0001;
    localparam logic [31:0] NOSTART = 32'hA500_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b1;
    logic        dbg_halt = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sys_rst_req, cpu_rst_req;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    guard_timer #(.DIV(DIV), .PULSE_LEN(4)) i_guard_timer (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .dbg_halt(dbg_halt),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sys_rst_req(sys_rst_req), .cpu_rst_req(cpu_rst_req)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk_mode(input logic stop, input logic halt_en,
        input logic cpu, input logic rst_en, input logic [11:0] win, input logic [11:0] rl);
        return {4'b0, stop, halt_en, cpu, rst_en, win, rl};
    endfunction

    function automatic int expect_timeout(input int n);
        return (n + 1) * DIV;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_req(input int limit);
        int n = 0;
        while (!(sys_rst_req || cpu_rst_req) && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_len(output int w);
        w = 0;
        while ((sys_rst_req || cpu_rst_req) && w < 20) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic watch_quiet(input int n, output bit seen);
        seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (sys_rst_req || cpu_rst_req) seen = 1;
        end
    endtask

    initial begin
        logic [31:0] d;
        int t0, w, nrl;
        logic cpu;
        bit seen;
        void'($urandom(32'd4242));

        // R1 reset state
        do_reset();
        check("R1 sys_rst_req", {31'b0, sys_rst_req}, 0);
        check("R1 cpu_rst_req", {31'b0, cpu_rst_req}, 0);
        rd(2'd2, d); check("R1 status", d, 32'h0FFF_0000);
        rd(2'd1, d); check("R1 mode", d, 32'h05FF_FFFF);

        // R2 R3 R11 random reload and target
        for (int i = 0; i < 6; i++) begin
            do_reset();
            nrl = $urandom_range(0, 5);
            cpu = 1'($urandom_range(0, 1));
            wr(2'd1, mk_mode(1'b0, 1'($urandom_range(0, 1)), cpu, 1'b1, 12'hFFF, 12'(nrl)));
            wr(2'd0, KEYED); t0 = cyc;
            rd(2'd2, d); check("R11 no window error", {31'b0, d[1]}, 0);
            wait_req(4000);
            check("R2 timeout", 32'(cyc - t0), 32'(expect_timeout(nrl)));
            check("R3 target cpu", {31'b0, cpu_rst_req}, {31'b0, cpu});
            check("R3 target sys", {31'b0, sys_rst_req}, {31'b0, !cpu});
            pulse_len(w);
            check("R3 pulse length", 32'(w), 4);
        end

        // R4 write once
        do_reset();
        wr(2'd1, mk_mode(1'b0, 1'b0, 1'b1, 1'b1, 12'hFFF, 12'd3));
        wr(2'd1, mk_mode(1'b1, 1'b1, 1'b0, 1'b0, 12'd5, 12'd9));
        rd(2'd1, d); check("R4 mode kept", d, mk_mode(1'b0, 1'b0, 1'b1, 1'b1, 12'hFFF, 12'd3));
        wr(2'd0, KEYED); t0 = cyc;
        wait_req(4000);
        check("R4 first config timeout", 32'(cyc - t0), 32'(expect_timeout(3)));
        check("R4 first config target", {31'b0, cpu_rst_req}, 1);

        // R5 unkeyed writes ignored
        do_reset();
        wr(2'd1, mk_mode(1'b0, 1'b0, 1'b0, 1'b1, 12'hFFF, 12'd5));
        wr(2'd0, KEYED); t0 = cyc;
        repeat (200) @(negedge clk);
        wr(2'd0, BADKEY);
        wr(2'd0, NOSTART);
        wait_req(4000);
        check("R5 unkeyed ignored", 32'(cyc - t0), 32'(expect_timeout(5)));

        // R6 disabled
        do_reset();
        wr(2'd1, mk_mode(1'b1, 1'b0, 1'b0, 1'b1, 12'hFFF, 12'd0));
        wr(2'd0, KEYED);
        watch_quiet(700, seen);
        check("R6 no request", {31'b0, seen}, 0);
        rd(2'd2, d); check("R6 counter frozen", {20'b0, d[27:16]}, 32'hFFF);
        rd(2'd1, d); check("R6 stop readable", {31'b0, d[27]}, 1);

        // R7 debug halt
        do_reset();
        wr(2'd1, mk_mode(1'b0, 1'b1, 1'b0, 1'b1, 12'hFFF, 12'd2));
        wr(2'd0, KEYED); t0 = cyc;
        dbg_halt = 1'b1;
        repeat (300) @(negedge clk);
        dbg_halt = 1'b0;
        wait_req(4000);
        check("R7 halt extends", 32'(cyc - t0), 32'(expect_timeout(2) + 300));

        // R8 window
        do_reset();
        wr(2'd1, mk_mode(1'b0, 1'b0, 1'b0, 1'b1, 12'd4, 12'd10));
        wr(2'd0, KEYED); t0 = cyc;
        check("R8 early restart raises request", {31'b0, sys_rst_req}, 1);
        rd(2'd2, d); check("R8 error flag", {31'b0, d[1]}, 1);
        while (cyc - t0 < 800) @(negedge clk);
        wr(2'd0, KEYED); t0 = cyc;
        check("R8 in-window no request", {31'b0, sys_rst_req}, 0);
        rd(2'd2, d); check("R8 in-window no error", {31'b0, d[1]}, 0);
        wait_req(4000);
        check("R8 in-window timeout", 32'(cyc - t0), 32'(expect_timeout(10)));

        // R9 R10 reset disabled, sticky status
        do_reset();
        wr(2'd1, mk_mode(1'b0, 1'b0, 1'b0, 1'b0, 12'hFFF, 12'd1));
        wr(2'd0, KEYED);
        watch_quiet(300, seen);
        check("R9 no request", {31'b0, seen}, 0);
        rd(2'd2, d); check("R10 underflow held", {31'b0, d[0]}, 1);
        rd(2'd2, d); check("R10 cleared by read", {31'b0, d[0]}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule